// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block performs the hardware side of taking a trap on a register-windowed processor. When a synchronous exception, a misaligned memory access or an asynchronous interrupt is pending and traps are enabled, it disables further traps and keeps the old supervisor bit in the previous-supervisor bit. It then moves the current window pointer down by one to a fresh trap window. It writes the interrupted PC and nPC into two local registers of that window, puts the trap code into the trap base register, and redirects fetch to the handler address. None of these actions destroys the old processor state, so a handler can undo them later.

The processor state (trap enable, supervisor, previous supervisor, window pointer, trap base register) lives outside the block. The block reads the current values and issues write strobes with new values. An architectural reset request overrides everything and restarts fetch at address 0. A synchronous trap raised while traps are disabled stops the block in an error halt. Only a reset leaves that halt.

Top module: `trap_entry_seq`

## Requirements
- R1: When a trap is accepted in the idle state with the enable-traps input at 1, the cycle after the accepting edge drives `st_we`=1 with `st_et`=0, `st_s`=1 and `st_ps` equal to the `cur_s` value seen at acceptance.
- R2: In that same cycle `st_cwp` equals the accepted `cur_cwp` minus one, modulo NWIN (0 becomes NWIN-1). This happens with no check of whether that window is valid.
- R3: In that same cycle the register-file port writes the accepted PC to index 17 of the new window. In the next cycle it writes the accepted nPC to index 18 of the same window.
- R4: In the state-update cycle `tbr_we`=1 and `tbr_val` keeps `cur_tbr` bits 31:12, puts the trap code into bits 11:4 and zeroes bits 3:0.
- R5: In the cycle of the nPC write, `redirect`=1 with `new_pc` equal to the new trap base value and `new_npc` equal to that value plus 4. After that the block is idle again (`busy`=0).
- R6: A `cpu_reset` request, taken in any state, gives one cycle with `redirect`=1, `new_pc`=0, `new_npc`=4, `st_we`=1, `st_et`=0, `st_s`=1, and `st_ps` and `st_cwp` equal to the values seen at the request. In that cycle there is no register-file or trap base write, and `err_halt` is 0.
- R7: An interrupt request while `cur_et`=0 is ignored: no state write, no register-file write and no redirect follow.
- R8: A synchronous trap while `cur_et`=0 raises `err_halt` in the next cycle. While halted, every request other than reset is ignored and no write or redirect is issued.
- R9: An access with `mem_req`=1 is misaligned when any of its low `mem_size` address bits is set. The size codes are 0 byte, 1 half-word, 2 word and 3 doubleword. A misaligned access raises a synchronous trap with code 7.
- R10: When several sources are pending, reset wins over an explicit synchronous trap, which wins over a misalignment fault, which wins over an interrupt. The chosen code is the one recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| cpu_reset | input | 1 | Architectural reset request |
| sync_req | input | 1 | Synchronous exception pending |
| sync_tt | input | 8 | Code of the synchronous exception |
| irq_req | input | 1 | Asynchronous interrupt pending |
| irq_tt | input | 8 | Code of the interrupt |
| mem_req | input | 1 | A memory access is being issued |
| mem_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| mem_addr_lo | input | 3 | Low three bits of the access address |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_npc | input | 32 | nPC of the interrupted instruction |
| cur_et | input | 1 | Current enable-traps bit |
| cur_s | input | 1 | Current supervisor bit |
| cur_ps | input | 1 | Current previous-supervisor bit |
| cur_cwp | input | 3 | Current window pointer |
| cur_tbr | input | 32 | Current trap base register |
| busy | output | 1 | Entry or reset sequence in progress |
| err_halt | output | 1 | Error halt after a synchronous trap with traps disabled |
| st_we | output | 1 | State-bit write strobe |
| st_et | output | 1 | New enable-traps bit |
| st_s | output | 1 | New supervisor bit |
| st_ps | output | 1 | New previous-supervisor bit |
| st_cwp | output | 3 | New window pointer |
| tbr_we | output | 1 | Trap base register write strobe |
| tbr_val | output | 32 | New trap base register value |
| rf_we | output | 1 | Register-file write strobe |
| rf_win | output | 3 | Window of the register-file write |
| rf_idx | output | 5 | Register index within the window |
| rf_wdata | output | 32 | Register-file write data |
| redirect | output | 1 | Fetch redirect strobe |
| new_pc | output | 32 | Redirect PC |
| new_npc | output | 32 | Redirect nPC |

## Verification
Some properties are checked on every cycle. Each state write clears the enable-traps bit. The window pointer written is one below the pointer seen the cycle before. Every redirect keeps nPC four above PC. A PC save is always followed by an nPC save. A halted block issues nothing. Other behaviour only shows up in the directed scenarios. These cover the exact codes placed in the trap base field and the priority order between simultaneous sources. They also cover the alignment decision for each access size, the reset values with untouched fields, and the fact that an interrupt is dropped when traps are disabled.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ENTER = 3'd1,
    SQ_SAVE  = 3'd2,
    SQ_RST   = 3'd3,
    SQ_HALT  = 3'd4
  } seq_state_e;

  localparam logic [7:0] TT_MISALIGN = 8'h07;
  localparam logic [4:0] IDX_SAVE_PC  = 5'd17;
  localparam logic [4:0] IDX_SAVE_NPC = 5'd18;
endpackage

// File: rtl/trap_align.sv
module trap_align #(
  parameter int unsigned LOW_W = 3
) (
  input  logic             mem_req,
  input  logic [1:0]       mem_size,
  input  logic [LOW_W-1:0] mem_addr_lo,
  output logic             fault
);
  logic [LOW_W-1:0] need_zero;

  // bit k must be zero when the access spans more than 2**k bytes
  for (genvar k = 0; k < LOW_W; k++) begin : g_mask
    assign need_zero[k] = (32'(mem_size) > k);
  end

  assign fault = mem_req && |(mem_addr_lo & need_zero);
endmodule

// File: rtl/trap_arb.sv
module trap_arb
  import trap_pkg::*;
#(
  parameter int unsigned TTW = 8
) (
  input  logic           cpu_reset,
  input  logic           sync_req,
  input  logic [TTW-1:0] sync_tt,
  input  logic           align_fault,
  input  logic           irq_req,
  input  logic [TTW-1:0] irq_tt,
  input  logic           cur_et,
  output logic           go_reset,
  output logic           go_trap,
  output logic           go_halt,
  output logic [TTW-1:0] sel_tt
);
  logic any_sync;

  assign any_sync = sync_req || align_fault;
  assign go_reset = cpu_reset;
  assign go_halt  = !cpu_reset && any_sync && !cur_et;
  assign go_trap  = !cpu_reset && cur_et && (any_sync || irq_req);

  always_comb begin
    if (sync_req)         sel_tt = sync_tt;
    else if (align_fault) sel_tt = TTW'(TT_MISALIGN);
    else                  sel_tt = irq_tt;
  end

  // R10: reset excludes every other choice
  always_comb begin
    if (cpu_reset) begin
      p_reset_first_r10: assert (!go_trap && !go_halt);
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned TTW    = 8,
  parameter int unsigned TT_LSB = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go_reset,
  input  logic                     go_trap,
  input  logic                     go_halt,
  input  logic [TTW-1:0]           sel_tt,
  input  logic [AW-1:0]            cur_pc,
  input  logic [AW-1:0]            cur_npc,
  input  logic                     cur_s,
  input  logic                     cur_ps,
  input  logic [$clog2(NWIN)-1:0]  cur_cwp,
  input  logic [AW-1:0]            cur_tbr,
  output logic                     busy,
  output logic                     err_halt,
  output logic                     st_we,
  output logic                     st_et,
  output logic                     st_s,
  output logic                     st_ps,
  output logic [$clog2(NWIN)-1:0]  st_cwp,
  output logic                     tbr_we,
  output logic [AW-1:0]            tbr_val,
  output logic                     rf_we,
  output logic [$clog2(NWIN)-1:0]  rf_win,
  output logic [4:0]               rf_idx,
  output logic [AW-1:0]            rf_wdata,
  output logic                     redirect,
  output logic [AW-1:0]            new_pc,
  output logic [AW-1:0]            new_npc
);
  localparam int unsigned CW     = $clog2(NWIN);
  localparam int unsigned TT_MSB = TT_LSB + TTW - 1;
  localparam logic [CW-1:0] TOP_WIN = CW'(NWIN - 1);

  seq_state_e      state_q, state_d;
  logic [AW-1:0]   pc_q, npc_q, tbr_q;
  logic [AW-1:0]   pc_d, npc_d, tbr_d;
  logic [CW-1:0]   cwp_q, cwp_d, cwp_dec;
  logic            s_q, ps_q, s_d, ps_d;
  logic            ld_en;

  assign cwp_dec = (cur_cwp == '0) ? TOP_WIN : cur_cwp - CW'(1);

  // next state
  always_comb begin
    state_d = state_q;
    ld_en   = 1'b0;
    pc_d    = pc_q;
    npc_d   = npc_q;
    tbr_d   = tbr_q;
    cwp_d   = cwp_q;
    s_d     = s_q;
    ps_d    = ps_q;
    if (go_reset) begin
      state_d = SQ_RST;
      ld_en   = 1'b1;
      ps_d    = cur_ps;
      cwp_d   = cur_cwp;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (go_halt) begin
            state_d = SQ_HALT;
          end else if (go_trap) begin
            state_d = SQ_ENTER;
            ld_en   = 1'b1;
            pc_d    = cur_pc;
            npc_d   = cur_npc;
            s_d     = cur_s;
            cwp_d   = cwp_dec;
            tbr_d   = cur_tbr;
            tbr_d[TT_MSB:TT_LSB] = sel_tt;
            tbr_d[TT_LSB-1:0]    = '0;
          end
        end
        SQ_ENTER: state_d = SQ_SAVE;
        SQ_SAVE:  state_d = SQ_IDLE;
        SQ_RST:   state_d = SQ_IDLE;
        SQ_HALT:  state_d = SQ_HALT;
        default:  state_d = SQ_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pc_q    <= '0;
      npc_q   <= '0;
      tbr_q   <= '0;
      cwp_q   <= '0;
      s_q     <= 1'b0;
      ps_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_en) begin
        pc_q  <= pc_d;
        npc_q <= npc_d;
        tbr_q <= tbr_d;
        cwp_q <= cwp_d;
        s_q   <= s_d;
        ps_q  <= ps_d;
      end
    end
  end

  // outputs decoded from the sequence state
  always_comb begin
    busy     = (state_q == SQ_ENTER) || (state_q == SQ_SAVE) || (state_q == SQ_RST);
    err_halt = (state_q == SQ_HALT);
    st_we    = 1'b0;
    st_et    = 1'b0;
    st_s     = 1'b1;
    st_ps    = 1'b0;
    st_cwp   = cwp_q;
    tbr_we   = 1'b0;
    tbr_val  = tbr_q;
    rf_we    = 1'b0;
    rf_win   = cwp_q;
    rf_idx   = IDX_SAVE_PC;
    rf_wdata = pc_q;
    redirect = 1'b0;
    new_pc   = tbr_q;
    new_npc  = tbr_q + AW'(4);
    unique case (state_q)
      SQ_ENTER: begin
        st_we  = 1'b1;
        st_ps  = s_q;
        tbr_we = 1'b1;
        rf_we  = 1'b1;
      end
      SQ_SAVE: begin
        rf_we    = 1'b1;
        rf_idx   = IDX_SAVE_NPC;
        rf_wdata = npc_q;
        redirect = 1'b1;
      end
      SQ_RST: begin
        st_we    = 1'b1;
        st_ps    = ps_q;
        redirect = 1'b1;
        new_pc   = '0;
        new_npc  = AW'(4);
      end
      default: ;
    endcase
  end

  // R1: every state write leaves traps disabled
  p_et_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !st_et);

  // R2: new window is one below the window seen at acceptance (modulo NWIN)
  p_cwp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && tbr_we) |->
      ((st_cwp == TOP_WIN) ? ($past(cur_cwp) == '0)
                           : ($past(cur_cwp) == st_cwp + CW'(1))));

  // R3: a PC save is always followed by the nPC save in the same window
  p_save_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_idx == IDX_SAVE_PC && !go_reset) |=>
      (rf_we && rf_idx == IDX_SAVE_NPC && $stable(rf_win)));

  // R5: every redirect keeps nPC one word after PC
  p_npc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (new_npc == new_pc + AW'(4)));

  // R8: error halt issues nothing
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |-> (!st_we && !rf_we && !tbr_we && !redirect));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned TTW    = 8,
  parameter int unsigned TT_LSB = 4,
  parameter int unsigned LOW_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_reset,
  input  logic                    sync_req,
  input  logic [TTW-1:0]          sync_tt,
  input  logic                    irq_req,
  input  logic [TTW-1:0]          irq_tt,
  input  logic                    mem_req,
  input  logic [1:0]              mem_size,
  input  logic [LOW_W-1:0]        mem_addr_lo,
  input  logic [AW-1:0]           cur_pc,
  input  logic [AW-1:0]           cur_npc,
  input  logic                    cur_et,
  input  logic                    cur_s,
  input  logic                    cur_ps,
  input  logic [$clog2(NWIN)-1:0] cur_cwp,
  input  logic [AW-1:0]           cur_tbr,
  output logic                    busy,
  output logic                    err_halt,
  output logic                    st_we,
  output logic                    st_et,
  output logic                    st_s,
  output logic                    st_ps,
  output logic [$clog2(NWIN)-1:0] st_cwp,
  output logic                    tbr_we,
  output logic [AW-1:0]           tbr_val,
  output logic                    rf_we,
  output logic [$clog2(NWIN)-1:0] rf_win,
  output logic [4:0]              rf_idx,
  output logic [AW-1:0]           rf_wdata,
  output logic                    redirect,
  output logic [AW-1:0]           new_pc,
  output logic [AW-1:0]           new_npc
);
  logic           align_fault;
  logic           go_reset, go_trap, go_halt;
  logic [TTW-1:0] sel_tt;

  trap_align #(.LOW_W(LOW_W)) u_align (
    .mem_req     (mem_req),
    .mem_size    (mem_size),
    .mem_addr_lo (mem_addr_lo),
    .fault       (align_fault)
  );

  trap_arb #(.TTW(TTW)) u_arb (
    .cpu_reset   (cpu_reset),
    .sync_req    (sync_req),
    .sync_tt     (sync_tt),
    .align_fault (align_fault),
    .irq_req     (irq_req),
    .irq_tt      (irq_tt),
    .cur_et      (cur_et),
    .go_reset    (go_reset),
    .go_trap     (go_trap),
    .go_halt     (go_halt),
    .sel_tt      (sel_tt)
  );

  trap_seq #(.NWIN(NWIN), .AW(AW), .TTW(TTW), .TT_LSB(TT_LSB)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_reset (go_reset),
    .go_trap  (go_trap),
    .go_halt  (go_halt),
    .sel_tt   (sel_tt),
    .cur_pc   (cur_pc),
    .cur_npc  (cur_npc),
    .cur_s    (cur_s),
    .cur_ps   (cur_ps),
    .cur_cwp  (cur_cwp),
    .cur_tbr  (cur_tbr),
    .busy     (busy),
    .err_halt (err_halt),
    .st_we    (st_we),
    .st_et    (st_et),
    .st_s     (st_s),
    .st_ps    (st_ps),
    .st_cwp   (st_cwp),
    .tbr_we   (tbr_we),
    .tbr_val  (tbr_val),
    .rf_we    (rf_we),
    .rf_win   (rf_win),
    .rf_idx   (rf_idx),
    .rf_wdata (rf_wdata),
    .redirect (redirect),
    .new_pc   (new_pc),
    .new_npc  (new_npc)
  );
endmodule

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_reset, sync_req, irq_req, mem_req;
  logic [7:0]  sync_tt, irq_tt;
  logic [1:0]  mem_size;
  logic [2:0]  mem_addr_lo;
  logic [31:0] cur_pc, cur_npc, cur_tbr;
  logic        cur_et, cur_s, cur_ps;
  logic [2:0]  cur_cwp;
  logic        busy, err_halt, st_we, st_et, st_s, st_ps, tbr_we, rf_we, redirect;
  logic [2:0]  st_cwp, rf_win;
  logic [4:0]  rf_idx;
  logic [31:0] tbr_val, rf_wdata, new_pc, new_npc;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  trap_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset),
    .sync_req(sync_req), .sync_tt(sync_tt), .irq_req(irq_req), .irq_tt(irq_tt),
    .mem_req(mem_req), .mem_size(mem_size), .mem_addr_lo(mem_addr_lo),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_et(cur_et), .cur_s(cur_s),
    .cur_ps(cur_ps), .cur_cwp(cur_cwp), .cur_tbr(cur_tbr),
    .busy(busy), .err_halt(err_halt), .st_we(st_we), .st_et(st_et),
    .st_s(st_s), .st_ps(st_ps), .st_cwp(st_cwp), .tbr_we(tbr_we),
    .tbr_val(tbr_val), .rf_we(rf_we), .rf_win(rf_win), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .redirect(redirect), .new_pc(new_pc), .new_npc(new_npc)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic clear_req();
    cpu_reset = 0; sync_req = 0; irq_req = 0; mem_req = 0;
  endtask

  // full entry: request driven for one cycle, then both sequence cycles checked
  task automatic run_entry(input string tag, input logic [7:0] exp_tt);
    logic [31:0] exp_tbr;
    logic [2:0]  exp_cwp;
    exp_tbr = {cur_tbr[31:12], exp_tt, 4'h0};
    exp_cwp = cur_cwp - 3'd1;
    @(negedge clk);
    chk({tag, " R1 st_we"}, 32'(st_we), 1);
    chk({tag, " R1 et"}, 32'(st_et), 0);
    chk({tag, " R1 s"}, 32'(st_s), 1);
    chk({tag, " R1 ps"}, 32'(st_ps), 32'(cur_s));
    chk({tag, " R2 cwp"}, 32'(st_cwp), 32'(exp_cwp));
    chk({tag, " R4 tbr_we"}, 32'(tbr_we), 1);
    chk({tag, " R4/R10 tbr"}, tbr_val, exp_tbr);
    chk({tag, " R3 pc save"}, {rf_we, 8'(rf_win), 8'(rf_idx)}, {1'b1, 8'(exp_cwp), 8'd17});
    chk({tag, " R3 pc data"}, rf_wdata, cur_pc);
    clear_req();
    @(negedge clk);
    chk({tag, " R3 npc save"}, {rf_we, 8'(rf_win), 8'(rf_idx)}, {1'b1, 8'(exp_cwp), 8'd18});
    chk({tag, " R3 npc data"}, rf_wdata, cur_npc);
    chk({tag, " R5 redirect"}, 32'(redirect), 1);
    chk({tag, " R5 pc"}, new_pc, exp_tbr);
    chk({tag, " R5 npc"}, new_npc, exp_tbr + 4);
    @(negedge clk);
    chk({tag, " R5 idle"}, 32'(busy), 0);
  endtask

  // expects nothing to happen for two cycles after one request cycle
  task automatic expect_quiet(input string tag);
    @(negedge clk);
    clear_req();
    chk({tag, " quiet 1"}, {busy, st_we, rf_we, redirect, tbr_we}, 0);
    @(negedge clk);
    chk({tag, " quiet 2"}, {busy, st_we, rf_we, redirect, tbr_we}, 0);
  endtask

  task automatic t_reset_state();
    chk("reset state", {busy, err_halt, st_we, rf_we, redirect, tbr_we}, 0);
  endtask

  task automatic t_sync_wrap();
    @(negedge clk);
    cur_et = 1; cur_s = 0; cur_ps = 1; cur_cwp = 3'd0;
    cur_pc = 32'h0000_1000; cur_npc = 32'h0000_1004; cur_tbr = 32'h4000_0ABC;
    sync_req = 1; sync_tt = 8'h2A;
    run_entry("sync wrap R2", 8'h2A);
  endtask

  task automatic t_irq();
    @(negedge clk);
    cur_et = 1; cur_s = 1; cur_cwp = 3'd3;
    cur_pc = 32'h0000_2220; cur_npc = 32'h0000_2224; cur_tbr = 32'h8765_4000;
    irq_req = 1; irq_tt = 8'h1B;
    run_entry("irq", 8'h1B);
  endtask

  task automatic t_irq_disabled();
    @(negedge clk);
    cur_et = 0; irq_req = 1; irq_tt = 8'h15;
    expect_quiet("R7 irq with traps off");
  endtask

  task automatic t_align();
    @(negedge clk);
    cur_et = 1; cur_s = 0; cur_cwp = 3'd5; cur_tbr = 32'h0001_0000;
    cur_pc = 32'h300; cur_npc = 32'h304;
    mem_req = 1; mem_size = 2'd2; mem_addr_lo = 3'd2;
    run_entry("R9 word at 2", 8'h07);
    @(negedge clk);
    mem_req = 1; mem_size = 2'd3; mem_addr_lo = 3'd4;
    run_entry("R9 double at 4", 8'h07);
    @(negedge clk);
    mem_req = 1; mem_size = 2'd1; mem_addr_lo = 3'd1;
    run_entry("R9 half at 1", 8'h07);
    @(negedge clk);
    mem_req = 1; mem_size = 2'd2; mem_addr_lo = 3'd4;
    expect_quiet("R9 word at 4 aligned");
    @(negedge clk);
    mem_req = 1; mem_size = 2'd0; mem_addr_lo = 3'd3;
    expect_quiet("R9 byte at 3 aligned");
  endtask

  task automatic t_priority();
    @(negedge clk);
    cur_et = 1; cur_cwp = 3'd7; cur_tbr = 32'h0000_0000;
    sync_req = 1; sync_tt = 8'h09; irq_req = 1; irq_tt = 8'h1F;
    mem_req = 1; mem_size = 2'd2; mem_addr_lo = 3'd1;
    run_entry("R10 sync over align and irq", 8'h09);
    @(negedge clk);
    mem_req = 1; mem_size = 2'd2; mem_addr_lo = 3'd3; irq_req = 1; irq_tt = 8'h1F;
    run_entry("R10 align over irq", 8'h07);
  endtask

  task automatic t_halt_and_reset();
    @(negedge clk);
    cur_et = 0; cur_ps = 0; cur_s = 0; cur_cwp = 3'd6;
    sync_req = 1; sync_tt = 8'h02;
    @(negedge clk);
    clear_req();
    chk("R8 halt raised", 32'(err_halt), 1);
    chk("R8 no writes", {st_we, rf_we, redirect, tbr_we}, 0);
    cur_et = 1; irq_req = 1; irq_tt = 8'h11;
    @(negedge clk);
    clear_req();
    @(negedge clk);
    chk("R8 irq ignored in halt", {err_halt, busy, st_we, rf_we, redirect}, 5'b10000);
    // reset together with a sync request: reset wins
    cur_ps = 1; cur_cwp = 3'd6; cur_tbr = 32'hAAAA_5555;
    cpu_reset = 1; sync_req = 1; sync_tt = 8'h03;
    @(negedge clk);
    clear_req();
    chk("R6 redirect", {redirect, new_pc, new_npc}, {1'b1, 32'd0, 32'd4});
    chk("R6 state", {st_we, st_et, st_s, st_ps}, 4'b1011);
    chk("R6 cwp kept", 32'(st_cwp), 6);
    chk("R6 no rf/tbr write", {rf_we, tbr_we}, 0);
    chk("R6 halt cleared", 32'(err_halt), 0);
    @(negedge clk);
    chk("R6 idle after reset", {busy, err_halt}, 0);
  endtask

  task automatic t_reset_mid_entry();
    @(negedge clk);
    cur_et = 1; cur_cwp = 3'd2; cur_ps = 0; irq_req = 1; irq_tt = 8'h12;
    @(negedge clk);
    clear_req();
    cpu_reset = 1;
    @(negedge clk);
    clear_req();
    chk("R6 reset overrides entry", {redirect, new_pc, rf_we, tbr_we}, {1'b1, 32'd0, 2'b00});
    chk("R6 reset ps/cwp", {st_ps, 3'(st_cwp)}, {1'b0, 3'd2});
    @(negedge clk);
  endtask

  initial begin
    clear_req();
    sync_tt = 0; irq_tt = 0; mem_size = 0; mem_addr_lo = 0;
    cur_pc = 0; cur_npc = 0; cur_tbr = 0; cur_et = 0; cur_s = 0; cur_ps = 0; cur_cwp = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_sync_wrap();
    t_irq();
    t_irq_disabled();
    t_align();
    t_priority();
    t_halt_and_reset();
    t_reset_mid_entry();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule